// File: doc/BRIEF.md
# E1 Frame Alignment Synchronizer

This block sits on the receive side of a 2.048 Mbit/s E1 link, after line decoding. It takes one serial bit per asserted bit enable and searches the stream for the 7-bit frame alignment word carried in timeslot 0 of every second frame. When it finds the word, it checks the next two frames and then declares alignment. From then on it drives a bit-in-timeslot counter, a timeslot counter and a flag that marks frames which carry the alignment word. Downstream logic uses these to pick channels out of the stream.

While aligned, the block keeps checking the alignment word. It also checks the fixed bit 2 of timeslot 0 in the alternate frames, but only when that rule is switched on. A one-cycle pulse reports each errored alignment word. A second pulse reports when an error criterion is met, and the block then goes back to searching unless automatic resync is disabled. A rising edge on the manual resync input restarts the search at any time.

Top module: `e1_frame_sync`

## Requirements
- R1: While rst_n is low and right after it is released, los is 1, bit_cnt, ts_cnt and fas_frame are 0, and frame_err and resync_met are 0.
- R2: While searching, the block compares each newly received bit together with the six before it against 0011011, where the oldest of the seven is bit 2 of timeslot 0. Only bits received since reset count. On a match, the bit just received is taken as bit_cnt 7 of timeslot 0 in an alignment frame (fas_frame 1).
- R3: A candidate survives only if, at the same position one frame later, the word does not match and bit 2 equals 1. If it fails, searching resumes with the next received bit.
- R4: If the word matches again one further frame later, los falls with the clock edge that takes in that bit. At that edge fas_frame is 1, ts_cnt is 0 and bit_cnt is 7.
- R5: bit_cnt, ts_cnt and fas_frame change only on cycles with bit_en high. bit_cnt counts 0 to 7 and then carries into ts_cnt, which counts 0 to 31. fas_frame inverts at every frame start.
- R6: While aligned, frame_err pulses for one cycle after each alignment frame whose word differs from 0011011.
- R7: Three alignment-word errors in a row pulse resync_met. With auto_resync_dis low, los rises at the same edge. A correct word clears the run.
- R8: With auto_resync_dis high, resync_met still pulses and los stays low. The error run then restarts from zero.
- R9: With bit2_rule_en high, three non-alignment frames in a row with bit 2 of timeslot 0 equal to 0 meet the criterion in the same way as R7 and R8. This rule never produces frame_err.
- R10: A 0-to-1 edge of resync_req makes los 1 from the next cycle and restarts the search. Holding the input high does not start another search; it must go low first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | rx_bit is valid this cycle |
| rx_bit | input | 1 | Serial receive data |
| auto_resync_dis | input | 1 | 1 keeps alignment when an error criterion is met |
| resync_req | input | 1 | Rising edge restarts the search |
| bit2_rule_en | input | 1 | Enables the non-alignment bit 2 criterion |
| bit_cnt | output | 3 | Bit index within the timeslot of the last received bit |
| ts_cnt | output | 5 | Timeslot index of the last received bit |
| fas_frame | output | 1 | Current frame carries the alignment word |
| los | output | 1 | Loss of sync: search in progress |
| frame_err | output | 1 | One-cycle pulse for an errored alignment word |
| resync_met | output | 1 | One-cycle pulse when an error criterion is met |

## Verification
Every registered output reflects the bit taken in at the preceding clock edge. A lock, an error pulse or a loss-of-sync change is therefore due exactly one edge after the enabled bit that causes it. A resync request takes effect one edge after the first cycle in which it reads high. The bench drives at the falling edge and compares at the next falling edge. There it checks all outputs against a model that it advances once per rising edge, so each result is checked in the cycle it is due. Random idle cycles between enabled bits confirm that nothing moves without bit_en.

// File: rtl/e1fs_pkg.sv
package e1fs_pkg;
  typedef enum logic [1:0] {
    ST_HUNT    = 2'd0,
    ST_ABSENT  = 2'd1,
    ST_PRESENT = 2'd2,
    ST_SYNC    = 2'd3
  } fs_state_t;

  localparam int FAS_LEN = 7;
endpackage

// File: rtl/e1fs_window.sv
module e1fs_window #(
  parameter int              W       = 7,
  parameter logic [W-1:0]    PATTERN = 7'b0011011
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic rx_bit,
  output logic match,
  output logic lead_bit
);
  logic [W-1:0] win_q;
  logic [W-1:0] win_nxt;

  // preset to ones so a match needs W bits received since reset
  always_comb begin
    win_nxt  = {win_q[W-2:0], rx_bit};
    match    = (win_nxt == PATTERN);
    lead_bit = win_nxt[W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      win_q <= '1;
    else if (bit_en) win_q <= win_nxt;
  end
endmodule

// File: rtl/e1fs_position.sv
module e1fs_position #(
  parameter int TS_N  = 32,
  parameter int BIT_N = 8,
  parameter int BIT_W = 3,
  parameter int TS_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             lock,
  output logic [BIT_W-1:0] bit_q,
  output logic [TS_W-1:0]  ts_q,
  output logic             fas_q,
  output logic             word_end
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BIT_N - 1);
  localparam logic [TS_W-1:0]  LAST_TS  = TS_W'(TS_N - 1);

  logic [BIT_W-1:0] bit_d;
  logic [TS_W-1:0]  ts_d;
  logic             fas_d;

  always_comb begin
    bit_d    = bit_q;
    ts_d     = ts_q;
    fas_d    = fas_q;
    word_end = 1'b0;
    if (bit_en) begin
      if (lock) begin
        bit_d = LAST_BIT;
        ts_d  = '0;
        fas_d = 1'b1;
      end else begin
        if (bit_q == LAST_BIT) begin
          bit_d = '0;
          if (ts_q == LAST_TS) begin
            ts_d  = '0;
            fas_d = ~fas_q;
          end else begin
            ts_d = ts_q + 1'b1;
          end
        end else begin
          bit_d = bit_q + 1'b1;
        end
        word_end = (bit_d == LAST_BIT) && (ts_d == '0);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= '0;
      ts_q  <= '0;
      fas_q <= 1'b0;
    end else if (bit_en) begin
      bit_q <= bit_d;
      ts_q  <= ts_d;
      fas_q <= fas_d;
    end
  end
endmodule

// File: rtl/e1fs_err_run.sv
module e1fs_err_run #(
  parameter int LIMIT = 3,
  parameter int CW    = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic chk,
  input  logic err,
  output logic hit
);
  logic [CW-1:0] run_q;
  logic [CW-1:0] run_d;

  always_comb begin
    hit   = chk && err && (run_q == CW'(LIMIT - 1));
    run_d = run_q;
    if (clr)      run_d = '0;
    else if (chk) run_d = (err && !hit) ? run_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end
endmodule

// File: rtl/e1_frame_sync.sv
module e1_frame_sync
  import e1fs_pkg::*;
#(
  parameter int                  TS_PER_FRAME = 32,
  parameter int                  BITS_PER_TS  = 8,
  parameter logic [FAS_LEN-1:0]  FAS_PATTERN  = 7'b0011011,
  parameter int                  FAS_ERR_RUN  = 3,
  parameter int                  B2_ERR_RUN   = 3,
  localparam int                 BIT_W        = $clog2(BITS_PER_TS),
  localparam int                 TS_W         = $clog2(TS_PER_FRAME)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             rx_bit,
  input  logic             auto_resync_dis,
  input  logic             resync_req,
  input  logic             bit2_rule_en,
  output logic [BIT_W-1:0] bit_cnt,
  output logic [TS_W-1:0]  ts_cnt,
  output logic             fas_frame,
  output logic             los,
  output logic             frame_err,
  output logic             resync_met
);
  fs_state_t state_q, state_d;
  logic      req_q;
  logic      req_edge;
  logic      word_match, bit2_val;
  logic      lock, word_end;
  logic      sync_chk, fas_chk, b2_chk;
  logic      hit_fas, hit_b2;
  logic      ferr_d, met_d;
  logic      ferr_q, met_q;

  e1fs_window #(.W(FAS_LEN), .PATTERN(FAS_PATTERN)) u_win (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
    .match(word_match), .lead_bit(bit2_val)
  );

  assign lock = bit_en && (state_q == ST_HUNT) && word_match;

  e1fs_position #(.TS_N(TS_PER_FRAME), .BIT_N(BITS_PER_TS),
                  .BIT_W(BIT_W), .TS_W(TS_W)) u_pos (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .lock(lock),
    .bit_q(bit_cnt), .ts_q(ts_cnt), .fas_q(fas_frame), .word_end(word_end)
  );

  assign req_edge = resync_req && !req_q;
  assign sync_chk = word_end && (state_q == ST_SYNC) && !req_edge;
  assign fas_chk  = sync_chk && fas_frame;
  assign b2_chk   = sync_chk && !fas_frame && bit2_rule_en;

  e1fs_err_run #(.LIMIT(FAS_ERR_RUN)) u_fas_run (
    .clk(clk), .rst_n(rst_n), .clr(state_q != ST_SYNC),
    .chk(fas_chk), .err(!word_match), .hit(hit_fas)
  );

  e1fs_err_run #(.LIMIT(B2_ERR_RUN)) u_b2_run (
    .clk(clk), .rst_n(rst_n), .clr(state_q != ST_SYNC),
    .chk(b2_chk), .err(!bit2_val), .hit(hit_b2)
  );

  always_comb begin
    state_d = state_q;
    if (req_edge) begin
      state_d = ST_HUNT;
    end else begin
      unique case (state_q)
        ST_HUNT:    if (lock) state_d = ST_ABSENT;
        ST_ABSENT:  if (word_end) state_d = (!word_match && bit2_val) ? ST_PRESENT : ST_HUNT;
        ST_PRESENT: if (word_end) state_d = word_match ? ST_SYNC : ST_HUNT;
        ST_SYNC:    if ((hit_fas || hit_b2) && !auto_resync_dis) state_d = ST_HUNT;
        default:    state_d = ST_HUNT;
      endcase
    end
    ferr_d = fas_chk && !word_match;
    met_d  = hit_fas || hit_b2;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      req_q   <= 1'b0;
      ferr_q  <= 1'b0;
      met_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      req_q   <= resync_req;
      ferr_q  <= ferr_d;
      met_q   <= met_d;
    end
  end

  assign los        = (state_q != ST_SYNC);
  assign frame_err  = ferr_q;
  assign resync_met = met_q;
endmodule

// File: rtl/e1fs_checker.sv
module e1fs_checker #(
  parameter int BIT_N = 8,
  parameter int TS_N  = 32,
  parameter int BIT_W = 3,
  parameter int TS_W  = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_en,
  input logic             resync_req,
  input logic             auto_resync_dis,
  input logic [BIT_W-1:0] bit_cnt,
  input logic [TS_W-1:0]  ts_cnt,
  input logic             fas_frame,
  input logic             los,
  input logic             frame_err,
  input logic             resync_met
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BIT_N - 1);
  localparam logic [TS_W-1:0]  LAST_TS  = TS_W'(TS_N - 1);

  p_lock_point_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(los) |-> (fas_frame && ts_cnt == '0 && bit_cnt == LAST_BIT));

  p_hold_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(bit_cnt) && $stable(ts_cnt) && $stable(fas_frame)));

  p_bit_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!los && bit_en) |=>
      (bit_cnt == (($past(bit_cnt) == LAST_BIT) ? '0 : $past(bit_cnt) + 1'b1)));

  p_fas_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!los && bit_en && ts_cnt == LAST_TS && bit_cnt == LAST_BIT) |=>
      (fas_frame != $past(fas_frame)));

  p_err_in_sync_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> !$past(los));

  p_err_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err);

  p_auto_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (resync_met && !$past(auto_resync_dis)) |-> los);

  p_keep_sync_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (resync_met && $past(auto_resync_dis)) |-> !los);

  p_manual_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resync_req) |=> los);
endmodule

bind e1_frame_sync e1fs_checker #(
  .BIT_N(BITS_PER_TS), .TS_N(TS_PER_FRAME), .BIT_W(BIT_W), .TS_W(TS_W)
) u_e1fs_checker (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .resync_req(resync_req),
  .auto_resync_dis(auto_resync_dis), .bit_cnt(bit_cnt), .ts_cnt(ts_cnt),
  .fas_frame(fas_frame), .los(los), .frame_err(frame_err), .resync_met(resync_met)
);

// File: tb/tb_e1_frame_sync.sv
module tb_e1_frame_sync;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;
  localparam logic [6:0] PAT = 7'b0011011;

  logic clk, rst_n, bit_en, rx_bit, auto_resync_dis, resync_req, bit2_rule_en;
  logic [2:0] bit_cnt;
  logic [4:0] ts_cnt;
  logic fas_frame, los, frame_err, resync_met;

  e1_frame_sync dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
    .auto_resync_dis(auto_resync_dis), .resync_req(resync_req),
    .bit2_rule_en(bit2_rule_en), .bit_cnt(bit_cnt), .ts_cnt(ts_cnt),
    .fas_frame(fas_frame), .los(los), .frame_err(frame_err), .resync_met(resync_met)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  string phase = "R1";
  logic c_auto = 1'b0, c_rule = 1'b0, c_req = 1'b0;
  int gfr = 0;

  // reference model state, advanced once per rising edge
  logic [6:0] m_win;
  int m_bit, m_ts, m_st, m_ec, m_bc;
  logic m_fas, m_req, m_ferr, m_met;

  task automatic chk(string tag, string name, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, name, act, exp);
    end
  endtask

  function automatic void model_clock(logic en, logic b, logic req);
    logic edge_r = req && !m_req;
    logic [6:0] wn = {m_win[5:0], b};
    logic mt = (wn == PAT);
    logic lock = en && (m_st == 0) && mt;
    int nb = m_bit, nts = m_ts, nst = m_st, nec = m_ec, nbc = m_bc;
    logic nf = m_fas, chkp = 1'b0, trig = 1'b0;
    m_ferr = 1'b0;
    m_met  = 1'b0;
    m_req  = req;
    if (en) begin
      if (lock) begin
        nb = 7; nts = 0; nf = 1'b1;
      end else begin
        nb = (m_bit + 1) % 8;
        if (m_bit == 7) begin
          nts = (m_ts + 1) % 32;
          if (m_ts == 31) nf = !m_fas;
        end
        chkp = (nb == 7) && (nts == 0);
      end
    end
    if (m_st != 3) begin nec = 0; nbc = 0; end
    if (edge_r) nst = 0;
    else if (en) begin
      case (m_st)
        0: if (mt) nst = 1;
        1: if (chkp) nst = (!mt && wn[6]) ? 2 : 0;
        2: if (chkp) nst = mt ? 3 : 0;
        default: if (chkp) begin
          if (m_fas) begin
            if (!mt) begin
              m_ferr = 1'b1;
              nec = m_ec + 1;
              if (nec == 3) begin trig = 1'b1; nec = 0; end
            end else nec = 0;
          end else if (c_rule) begin
            if (!wn[6]) begin
              nbc = m_bc + 1;
              if (nbc == 3) begin trig = 1'b1; nbc = 0; end
            end else nbc = 0;
          end
          if (trig) begin
            m_met = 1'b1;
            if (!c_auto) nst = 0;
          end
        end
      endcase
    end
    if (en) begin m_win = wn; m_bit = nb; m_ts = nts; m_fas = nf; end
    m_st = nst; m_ec = nec; m_bc = nbc;
  endfunction

  task automatic compare_all();
    chk(phase, "los", int'(los), (m_st != 3) ? 1 : 0);
    chk("R5", "bit_cnt", int'(bit_cnt), m_bit);
    chk("R5", "ts_cnt", int'(ts_cnt), m_ts);
    chk("R5", "fas_frame", int'(fas_frame), int'(m_fas));
    chk("R6", "frame_err", int'(frame_err), int'(m_ferr));
    chk(phase, "resync_met", int'(resync_met), int'(m_met));
  endtask

  task automatic step(logic en, logic b);
    @(negedge clk);
    compare_all();
    bit_en = en; rx_bit = b;
    auto_resync_dis = c_auto; bit2_rule_en = c_rule; resync_req = c_req;
    model_clock(en, b, c_req);
  endtask

  task automatic send_bit(logic b);
    if ($urandom % 3 == 0) step(1'b0, 1'b0);
    step(1'b1, b);
  endtask

  // align frames have the word corrupted at bit 4 when bad_fas
  task automatic send_frame(logic bad_fas, logic bad_b2);
    logic align = (gfr % 2 == 0);
    for (int ts = 0; ts < 32; ts++) begin
      for (int k = 1; k <= 8; k++) begin
        logic b = logic'($urandom % 2);
        if (ts == 0 && align && k >= 2) begin
          b = PAT[8-k];
          if (bad_fas && k == 4) b = !b;
        end
        if (ts == 0 && !align && k == 2) b = !bad_b2;
        send_bit(b);
      end
    end
    gfr++;
  endtask

  task automatic sync_up();
    for (int k = 0; k < 40 && m_st != 3; k++) send_frame(1'b0, 1'b0);
    send_frame(1'b0, 1'b0);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG);
    finish_run();
  end

  initial begin
    void'($urandom(32'h1e1f));
    rst_n = 1'b0; bit_en = 1'b0; rx_bit = 1'b0;
    auto_resync_dis = 1'b0; resync_req = 1'b0; bit2_rule_en = 1'b0;
    m_win = 7'h7f; m_bit = 0; m_ts = 0; m_st = 0; m_ec = 0; m_bc = 0;
    m_fas = 1'b0; m_req = 1'b0; m_ferr = 1'b0; m_met = 1'b0;
    @(negedge clk);
    // R1: reset values while held in reset
    chk("R1", "los in reset", int'(los), 1);
    chk("R1", "bit_cnt in reset", int'(bit_cnt), 0);
    chk("R1", "ts_cnt in reset", int'(ts_cnt), 0);
    chk("R1", "fas_frame in reset", int'(fas_frame), 0);
    chk("R1", "pulses in reset", int'(frame_err) + int'(resync_met), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);

    phase = "R2";  // random noise while hunting
    for (int i = 0; i < 200; i++) send_bit(logic'($urandom % 2));

    phase = "R4";
    sync_up();
    chk("R4", "aligned after clean frames", int'(los), 0);

    phase = "R5";
    for (int i = 0; i < 6; i++) send_frame(1'b0, 1'b0);

    phase = "R7";  // two errors, a good word, then three in a row
    for (int i = 0; i < 4; i++) send_frame(1'b1, 1'b0);
    for (int i = 0; i < 2; i++) send_frame(1'b0, 1'b0);
    for (int i = 0; i < 6; i++) send_frame(1'b1, 1'b0);
    sync_up();

    phase = "R8";
    c_auto = 1'b1;
    for (int i = 0; i < 12; i++) send_frame(1'b1, 1'b0);
    chk("R8", "still aligned with auto resync off", int'(los), 0);
    c_auto = 1'b0;
    for (int i = 0; i < 2; i++) send_frame(1'b0, 1'b0);

    phase = "R9";
    c_rule = 1'b1;
    for (int i = 0; i < 2; i++) send_frame(1'b0, 1'b0);
    for (int i = 0; i < 6; i++) send_frame(1'b0, 1'b1);
    sync_up();
    c_rule = 1'b0;

    phase = "R3";  // restart, then candidates fail their middle-frame check
    c_req = 1'b1; send_bit(1'b0); c_req = 1'b0; send_bit(1'b1);
    for (int i = 0; i < 4; i++) send_frame(1'b0, 1'b1);
    sync_up();

    phase = "R10";  // held high: only the first edge counts
    for (int i = 0; i < 50; i++) send_bit(logic'($urandom % 2));
    c_req = 1'b1;
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    chk("R10", "los after request edge", int'(los), 1);
    sync_up();
    chk("R10", "held request does not retrigger", int'(los), 0);
    c_req = 1'b0;
    send_frame(1'b0, 1'b0);
    c_req = 1'b1;
    send_frame(1'b0, 1'b0);
    c_req = 1'b0;
    sync_up();
    step(1'b0, 1'b0);
    finish_run();
  end
endmodule